// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Target

This block is an I2C target that holds six 8-bit configuration bytes and presents all of them in parallel to the surrounding logic. It has no register pointer. A write always fills the bytes in order from byte 0 upward. A read always returns a byte-count value first and then every configuration byte. The bus lines are sampled by the block's own fast clock. SCL and SDA each pass through a two-stage synchroniser. The block pulls SDA low through an open-drain enable.

A write transaction runs as follows. The controller sends a start, then the write address (8-bit form 0xD2), then two header bytes, then data bytes. The block acknowledges both header bytes and discards their values. Data bytes then load byte 0, byte 1 and so on, and the controller may stop after any whole byte. A read transaction runs as follows. The controller sends the read address (0xD3), and the block then shifts out the count 6 followed by bytes 0 to 5, each MSB first, for as long as the controller acknowledges.

The sequencer has seven states. IDLE waits for a start. ADDR shifts in the address byte; it moves to ADDR_ACK on a match, or back to IDLE on a mismatch. ADDR_ACK moves to WR_BYTE for a write or to RD_BYTE for a read. WR_BYTE moves to WR_ACK while there is room, or to IDLE for a byte beyond the sixth data byte. WR_ACK returns to WR_BYTE. RD_BYTE moves to RD_ACK. RD_ACK moves to RD_BYTE when the controller acknowledged and bytes remain, and to IDLE otherwise. From any state, a start condition jumps to ADDR and resets the byte sequence, and a stop condition jumps to IDLE.

Top module: `i2c_blockcfg_target`

## Requirements
- R1: The block acknowledges an address byte of 0xD2 (write) or 0xD3 (read) by driving SDA low during the ninth clock.
- R2: Any other address byte is not acknowledged. The block then releases SDA and ignores the bus until the next start, so later bytes are neither acknowledged nor stored.
- R3: In a write, the first two bytes after the address are acknowledged, and neither byte changes any register.
- R4: In a write, the third byte onward is acknowledged and stored into register byte 0, then 1, then 2 and so on, in that order.
- R5: A stop after any complete data byte keeps the bytes already received, and registers not reached keep their previous values.
- R6: A seventh or later data byte in one write is not acknowledged and changes no register.
- R7: A read returns the count value 0x06 and then bytes 0 to 5, each MSB first. SDA changes only after SCL falls.
- R8: When the controller does not acknowledge a read byte, the block stops driving SDA and returns to idle.
- R9: A repeated start resets the sequencer, so the next write's data again begins at byte 0 after two discarded header bytes.
- R10: Reset sets byte 0 to 0x00, byte 1 to 0xFF and bytes 2 to 5 to 0x00.
- R11: Register byte k appears on cfg_bytes[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_bytes | output | 48 | All configuration bytes, byte k at bits 8k+7:8k |

## Verification
The hardest conditions to reach from the ports are two. One is a repeated start that arrives while a write is midway through its data bytes. The other is a read the controller cuts short with a NACK on an arbitrary byte, after which the block must already have let go of SDA. The bench drives SCL and SDA through a bit-level controller model and issues directed transactions that stop, restart or refuse a byte at chosen points. It mixes these with seeded random writes of 0 to 6 data bytes, random partial reads and misaddressed writes. After every transaction it compares cfg_bytes with a bench register model.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } state_e;

endpackage

// File: rtl/i2cbc_line_sync.sv
module i2cbc_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    // two synchroniser stages plus one history stage, idle bus is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_p <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_in;
            scl_s <= scl_m;
            scl_p <= scl_s;
            sda_m <= sda_in;
            sda_s <= sda_m;
            sda_p <= sda_s;
        end
    end

    assign sda_hi    = sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cbc_regbank.sv
module i2cbc_regbank #(
    parameter int                      NUM_REGS  = 6,
    parameter int                      IDX_W     = 4,
    parameter logic [NUM_REGS*8-1:0]   RESET_VAL = 48'h0000_0000_FF00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    output logic [NUM_REGS*8-1:0]   bytes_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val <= RESET_VAL[g*8 +: 8];
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                val <= wr_data;
            end
        end
        assign bytes_o[g*8 +: 8] = val;
    end

endmodule

// File: rtl/i2c_blockcfg_target.sv
module i2c_blockcfg_target #(
    parameter int                      NUM_REGS  = 6,
    parameter logic [6:0]              DEV_ADDR  = 7'h69,
    parameter logic [NUM_REGS*8-1:0]   RESET_VAL = 48'h0000_0000_FF00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_oe,
    output logic [NUM_REGS*8-1:0]   cfg_bytes
);
    import i2cbc_pkg::*;

    localparam int WB_W = $clog2(NUM_REGS + 3);
    localparam int RB_W = $clog2(NUM_REGS + 1);
    localparam logic [WB_W-1:0] WB_ONE   = 1;
    localparam logic [WB_W-1:0] WB_FIRST = 2;
    localparam logic [WB_W-1:0] WB_END   = WB_W'(NUM_REGS + 2);
    localparam logic [RB_W-1:0] RB_ONE   = 1;
    localparam logic [RB_W-1:0] RB_END   = RB_W'(NUM_REGS);
    localparam logic [7:0]      COUNT_B  = 8'(NUM_REGS);

    logic sda_hi, scl_rise, scl_fall, start_det, stop_det;

    state_e            st, st_d;
    logic [3:0]        cnt, cnt_d;
    logic [7:0]        sh, sh_d;
    logic [7:0]        tx, tx_d;
    logic [WB_W-1:0]   widx, widx_d;
    logic [RB_W-1:0]   ridx, ridx_d;
    logic              ack_ok, ack_d;

    logic              wr_en;
    logic [WB_W-1:0]   wr_idx;
    logic              byte_end;
    logic              addr_match;
    logic              wr_room;

    i2cbc_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_hi    (sda_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cbc_regbank #(
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (WB_W),
        .RESET_VAL (RESET_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (sh),
        .bytes_o (cfg_bytes)
    );

    function automatic logic [7:0] pick_byte(input logic [NUM_REGS*8-1:0] v,
                                             input logic [RB_W-1:0] i);
        logic [7:0] r;
        r = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (i == RB_W'(k)) r = v[k*8 +: 8];
        end
        return r;
    endfunction

    assign byte_end   = scl_fall && (cnt == 4'd8);
    assign addr_match = (sh[7:1] == DEV_ADDR);
    assign wr_room    = (widx < WB_END);
    assign wr_idx     = widx - WB_FIRST;
    assign wr_en      = (st == ST_WR_BYTE) && byte_end && wr_room &&
                        (widx >= WB_FIRST) && !start_det && !stop_det;

    // next-state and datapath
    always_comb begin
        st_d   = st;
        cnt_d  = cnt;
        sh_d   = sh;
        tx_d   = tx;
        widx_d = widx;
        ridx_d = ridx;
        ack_d  = ack_ok;
        if (start_det) begin
            st_d   = ST_ADDR;
            cnt_d  = '0;
            sh_d   = '0;
            widx_d = '0;
            ridx_d = '0;
        end else if (stop_det) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt_d = '0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_d  = {sh[6:0], sda_hi};
                        cnt_d = cnt + 4'd1;
                    end else if (byte_end) begin
                        cnt_d = '0;
                        st_d  = addr_match ? ST_ADDR_ACK : ST_IDLE;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_rise) begin
                        cnt_d = 4'd1;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt_d = '0;
                        if (sh[0]) begin
                            st_d = ST_RD_BYTE;
                            tx_d = COUNT_B;
                        end else begin
                            st_d = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        sh_d  = {sh[6:0], sda_hi};
                        cnt_d = cnt + 4'd1;
                    end else if (byte_end) begin
                        cnt_d = '0;
                        st_d  = wr_room ? ST_WR_ACK : ST_IDLE;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_rise) begin
                        cnt_d = 4'd1;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt_d  = '0;
                        widx_d = widx + WB_ONE;
                        st_d   = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        cnt_d = cnt + 4'd1;
                    end else if (byte_end) begin
                        cnt_d = '0;
                        st_d  = ST_RD_ACK;
                    end else if (scl_fall) begin
                        tx_d = {tx[6:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        cnt_d = 4'd1;
                        ack_d = ~sda_hi;
                    end else if (scl_fall && cnt == 4'd1) begin
                        cnt_d = '0;
                        if (ack_ok && ridx < RB_END) begin
                            tx_d   = pick_byte(cfg_bytes, ridx);
                            ridx_d = ridx + RB_ONE;
                            st_d   = ST_RD_BYTE;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            widx   <= '0;
            ridx   <= '0;
            ack_ok <= 1'b0;
        end else begin
            st     <= st_d;
            cnt    <= cnt_d;
            sh     <= sh_d;
            tx     <= tx_d;
            widx   <= widx_d;
            ridx   <= ridx_d;
            ack_ok <= ack_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx[7];
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2cbc_checker.sv
module i2cbc_checker #(
    parameter int NUM_REGS = 6,
    parameter int WB_W     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sda_oe,
    input logic                   scl_fall,
    input logic                   start_det,
    input logic                   stop_det,
    input i2cbc_pkg::state_e      st,
    input logic                   wr_en,
    input logic [WB_W-1:0]        wr_idx,
    input logic [NUM_REGS*8-1:0]  cfg_bytes
);
    import i2cbc_pkg::*;

    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    p_sda_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    p_wr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < WB_W'(NUM_REGS)));

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_bytes));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE));

endmodule

bind i2c_blockcfg_target i2cbc_checker #(
    .NUM_REGS (NUM_REGS),
    .WB_W     (WB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st        (st),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .cfg_bytes (cfg_bytes)
);

// File: tb/i2c_blockcfg_target_test.sv
`timescale 1ns/1ps
module i2c_blockcfg_target_test;

    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_ctl = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [47:0] cfg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] model [6];
    logic [7:0] wdat  [8];

    always #5 clk = ~clk;

    assign sda_line = ~(sda_ctl | sda_oe);

    i2c_blockcfg_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg)
    );

    function automatic logic [47:0] model_vec();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 6; i++) model[i] = 8'h00;
        model[1] = 8'hFF;
    endfunction

    function automatic bit exp_wr_ack(input int i);
        return (i < 6);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctl = 1'b0; scl = 1'b1; hw(H);
        sda_ctl = 1'b1; hw(H);
        scl = 1'b0; hw(H);
    endtask

    task automatic bus_restart();
        sda_ctl = 1'b0; hw(H);
        scl = 1'b1; hw(H);
        sda_ctl = 1'b1; hw(H);
        scl = 1'b0; hw(H);
    endtask

    task automatic bus_stop();
        sda_ctl = 1'b1; hw(H);
        scl = 1'b1; hw(H);
        sda_ctl = 1'b0; hw(H);
    endtask

    task automatic send_bit(input logic b);
        sda_ctl = ~b; hw(H);
        scl = 1'b1; hw(H);
        scl = 1'b0; hw(2);
    endtask

    task automatic recv_bit(output logic b);
        sda_ctl = 1'b0; hw(H);
        scl = 1'b1; hw(H/2);
        b = sda_line; hw(H/2);
        scl = 1'b0; hw(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = ~a;
        sda_ctl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
        sda_ctl = 1'b0;
    endtask

    // write with n data bytes taken from wdat
    task automatic write_txn(input int n);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack);
        chk("R1 write address ack", 64'(ack), 64'd1);
        send_byte(8'($urandom), ack);
        chk("R3 command byte ack", 64'(ack), 64'd1);
        send_byte(8'($urandom), ack);
        chk("R3 count byte ack", 64'(ack), 64'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], ack);
            chk(exp_wr_ack(i) ? "R4 data byte ack" : "R6 overflow byte nack",
                64'(ack), 64'(exp_wr_ack(i)));
            if (exp_wr_ack(i)) model[i] = wdat[i];
        end
        bus_stop();
        chk("R4 R5 R11 registers after write", 64'(cfg), 64'(model_vec()));
    endtask

    // read count byte then k register bytes; last byte nacked when nack_last
    task automatic read_txn(input int k, input bit nack_last);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, ack);
        chk("R1 read address ack", 64'(ack), 64'd1);
        recv_byte(!(nack_last && k == 0), v);
        chk("R7 count byte", 64'(v), 64'h06);
        for (int i = 0; i < k; i++) begin
            recv_byte(!(nack_last && i == k - 1), v);
            chk("R7 read data byte", 64'(v), 64'(model[i]));
        end
        if (nack_last) begin
            hw(6);
            chk("R8 sda released after nack", 64'({sda_oe, sda_line}), 64'b01);
        end
        bus_stop();
    endtask

    task automatic bad_addr_txn();
        logic ack;
        bus_start();
        send_byte(8'hA4, ack);
        chk("R2 foreign address nack", 64'(ack), 64'd0);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'($urandom), ack);
            chk("R2 bytes ignored after mismatch", 64'(ack), 64'd0);
        end
        bus_stop();
        chk("R2 registers untouched", 64'(cfg), 64'(model_vec()));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        void'($urandom(32'd4711));
        model_reset();
        hw(5);
        chk("R10 reset defaults", 64'(cfg), 64'(model_vec()));
        chk("R10 sda idle", 64'(sda_oe), 64'd0);
        rst_n = 1'b1;
        hw(5);

        // full write then full read
        for (int i = 0; i < 8; i++) wdat[i] = 8'($urandom);
        write_txn(6);
        read_txn(6, 1'b0);

        // header bytes only: nothing changes
        write_txn(0);

        // partial write
        for (int i = 0; i < 8; i++) wdat[i] = 8'($urandom);
        write_txn(2);

        // overflow
        for (int i = 0; i < 8; i++) wdat[i] = 8'($urandom);
        write_txn(8);

        // early nack
        read_txn(3, 1'b1);
        read_txn(0, 1'b1);

        bad_addr_txn();

        // repeated start in the middle of a write
        begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            bus_start();
            send_byte(8'hD2, ack);
            send_byte(8'h11, ack);
            send_byte(8'h22, ack);
            send_byte(a, ack);
            send_byte(8'h5A, ack);
            bus_restart();
            send_byte(8'hD2, ack);
            chk("R9 address ack after restart", 64'(ack), 64'd1);
            send_byte(8'h33, ack);
            send_byte(8'h44, ack);
            send_byte(b, ack);
            bus_stop();
            model[0] = b;
            model[1] = 8'h5A;
            chk("R9 restart reloads from byte 0", 64'(cfg), 64'(model_vec()));
        end

        // random mix
        for (int t = 0; t < 16; t++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                for (int i = 0; i < 8; i++) wdat[i] = 8'($urandom);
                write_txn(int'($urandom % 7));
            end else if (op == 1) begin
                read_txn(6, 1'b0);
            end else if (op == 2) begin
                read_txn(1 + int'($urandom % 6), 1'b1);
            end else begin
                bad_addr_txn();
            end
        end

        // reset again
        rst_n = 1'b0;
        hw(3);
        model_reset();
        chk("R10 defaults after second reset", 64'(cfg), 64'(model_vec()));
        rst_n = 1'b1;
        hw(3);
        read_txn(6, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule